// File: doc/BRIEF.md
# Triggered Compare-and-Clear Unit

This unit sits beside a pulse or position counter. When a trigger occurs, it compares the counter's present value against a programmed top value. If the chosen comparison holds, it sends a one-cycle clear strobe back to the counter and sets a sticky match flag. The counter itself lives elsewhere. This block sees only its value.

A trigger comes from one of two sources, chosen by a trigger-mode field:

- **Slow-clock mode.** The source is a one-cycle tick that marks each cycle of a slow reference clock. A prescaler divides it by 1, 2, 4 or 8.
- **Event mode.** The source is a rising edge on one of six event channels. The channel's polarity can be inverted before the edge is detected.

The comparison can be:

- count at or below the top value;
- count at or above the top value;
- a window, with the top value's upper half as the inclusive upper bound and its lower half as the inclusive lower bound.

The selected event level is also offered as a count-gate output when gating is enabled.

Top module: `cmpclr_unit`

## Requirements
- R1: After a synchronous reset, clear_pulse and match_flag are 0 and count_gate is 1.
- R2: Trigger-mode codes 0 (off) and 3 (reserved) produce no clear_pulse, whatever ticks or event edges arrive.
- R3: In trigger mode 1, prescaler code p (0..3) makes every (2^p)-th slow_tick a trigger. The clear_pulse appears on the clock edge that samples that tick.
- R4: The prescaler restarts whenever trig_mode or presc changes. A tick in the same cycle as the change is ignored, and the first trigger comes after a full period of further ticks.
- R5: In trigger mode 2, a rising edge of the selected channel's (possibly inverted) level is a trigger, seen on the edge that samples the new level. Slow ticks are ignored in mode 2, and event edges are ignored in mode 1.
- R6: With ev_invert = 1, the selected channel's level is inverted before edge detection, so a falling edge of the raw input triggers.
- R7: Channel-select codes 6 and 7 select no channel. They give no trigger and a selected level of 0.
- R8: Compare code 0 matches when count <= top_val.
- R9: Compare code 1 matches when count >= top_val.
- R10: Compare code 2 matches when top_val[7:0] <= count <= top_val[15:8], with both bounds inclusive and zero-extended. Compare code 3 never matches.
- R11: Each matching trigger gives exactly one single-cycle clear_pulse and sets match_flag. match_flag stays set until flag_clr, and a match in the same cycle as flag_clr leaves it set.
- R12: count_gate is 1 when gate_en = 0. Otherwise it is the selected (polarity-applied) event level, registered one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle pulse per slow reference clock cycle |
| count | input | 16 | Current counter value |
| top_val | input | 16 | Top value, or upper/lower window bounds |
| trig_mode | input | 2 | 0 off, 1 prescaled slow clock, 2 event edge, 3 off |
| presc | input | 2 | Slow-clock divide code: divide by 2^code |
| cmp_mode | input | 2 | 0 at-or-below, 1 at-or-above, 2 window, 3 never |
| ev_in | input | 6 | Event channels |
| ev_sel | input | 3 | Event channel select, 0..5 valid |
| ev_invert | input | 1 | Invert the selected event level |
| gate_en | input | 1 | Drive count_gate from the selected event level |
| flag_clr | input | 1 | Clear the sticky match flag |
| clear_pulse | output | 1 | One-cycle clear strobe to the counter |
| match_flag | output | 1 | Sticky match indication |
| count_gate | output | 1 | Count enable derived from the event level |

## Verification
clear_pulse and match_flag are registered on the same clock edge that samples the triggering tick or the new event level, so each is due one edge after its stimulus. count_gate follows its inputs with the same one-edge delay. The bench applies every stimulus just after a rising edge, advances exactly one edge, and samples one nanosecond later. After each pulse check, it advances one idle edge to confirm that the strobe has dropped. Prescaler periods are checked tick by tick over sixteen ticks per divide code, with an idle cycle between ticks. Comparison results are checked with directed bound values and with random count, top and mode values, using a one-tick trigger.

// File: rtl/cmpclr_pkg.sv
package cmpclr_pkg;

  typedef enum logic [1:0] {
    TRG_OFF   = 2'd0,
    TRG_SLOW  = 2'd1,
    TRG_EVENT = 2'd2,
    TRG_RSVD  = 2'd3
  } trig_mode_e;

  typedef enum logic [1:0] {
    CMP_LE   = 2'd0,
    CMP_GE   = 2'd1,
    CMP_WIN  = 2'd2,
    CMP_RSVD = 2'd3
  } cmp_mode_e;

endpackage

// File: rtl/cmpclr_prescaler.sv
// Divides the slow-clock tick by 2^code; restarts on request.
module cmpclr_prescaler #(
  parameter int PRESC_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slow_tick,
  input  logic               enable,
  input  logic               restart,
  input  logic [PRESC_W-1:0] code,
  output logic               fire
);
  localparam int CNT_W = (1 << PRESC_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             at_limit;
  logic             counting;

  always_comb begin
    limit    = CNT_W'((32'd1 << code) - 32'd1);
    at_limit = (cnt_q == limit);
    counting = enable && !restart && slow_tick;
    fire     = counting && at_limit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (restart || !enable) begin
      cnt_q <= '0;
    end else if (counting) begin
      cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cmpclr_event.sv
// Selects one event channel, applies polarity, detects rising edges
// and produces the registered count-gate level.
module cmpclr_event #(
  parameter int NCH   = 6,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   ev_in,
  input  logic [SEL_W-1:0] ev_sel,
  input  logic             ev_invert,
  input  logic             gate_en,
  output logic             rise,
  output logic             count_gate
);
  logic sel_valid;
  logic lvl;
  logic lvl_q;

  always_comb begin
    sel_valid = (32'(ev_sel) < NCH);
    lvl       = sel_valid ? (ev_in[ev_sel] ^ ev_invert) : 1'b0;
    rise      = lvl && !lvl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q      <= 1'b0;
      count_gate <= 1'b1;
    end else begin
      lvl_q      <= lvl;
      count_gate <= gate_en ? lvl : 1'b1;
    end
  end
endmodule

// File: rtl/cmpclr_compare.sv
// Combinational compare of count against top value or window bounds.
module cmpclr_compare
  import cmpclr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] top_val,
  input  logic [1:0]    mode,
  output logic          hit
);
  localparam int HALF = CW / 2;

  logic [CW-1:0] win_hi;
  logic [CW-1:0] win_lo;
  cmp_mode_e     m;

  always_comb begin
    m      = cmp_mode_e'(mode);
    win_hi = CW'(top_val[CW-1:HALF]);
    win_lo = CW'(top_val[HALF-1:0]);
    unique case (m)
      CMP_LE:  hit = (count <= top_val);
      CMP_GE:  hit = (count >= top_val);
      CMP_WIN: hit = (count <= win_hi) && (count >= win_lo);
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmpclr_unit.sv
module cmpclr_unit
  import cmpclr_pkg::*;
#(
  parameter int CW      = 16,
  parameter int NCH     = 6,
  parameter int SEL_W   = 3,
  parameter int PRESC_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slow_tick,
  input  logic [CW-1:0]      count,
  input  logic [CW-1:0]      top_val,
  input  logic [1:0]         trig_mode,
  input  logic [PRESC_W-1:0] presc,
  input  logic [1:0]         cmp_mode,
  input  logic [NCH-1:0]     ev_in,
  input  logic [SEL_W-1:0]   ev_sel,
  input  logic               ev_invert,
  input  logic               gate_en,
  input  logic               flag_clr,
  output logic               clear_pulse,
  output logic               match_flag,
  output logic               count_gate
);
  trig_mode_e         tm;
  logic [1:0]         mode_q;
  logic [PRESC_W-1:0] presc_q;
  logic               restart;
  logic               slow_fire;
  logic               ev_rise;
  logic               hit;
  logic               trig;
  logic               match;

  always_comb begin
    tm      = trig_mode_e'(trig_mode);
    restart = (trig_mode != mode_q) || (presc != presc_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      presc_q <= '0;
    end else begin
      mode_q  <= trig_mode;
      presc_q <= presc;
    end
  end

  cmpclr_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk       (clk),
    .rst       (rst),
    .slow_tick (slow_tick),
    .enable    (tm == TRG_SLOW),
    .restart   (restart),
    .code      (presc),
    .fire      (slow_fire)
  );

  cmpclr_event #(.NCH(NCH), .SEL_W(SEL_W)) u_event (
    .clk        (clk),
    .rst        (rst),
    .ev_in      (ev_in),
    .ev_sel     (ev_sel),
    .ev_invert  (ev_invert),
    .gate_en    (gate_en),
    .rise       (ev_rise),
    .count_gate (count_gate)
  );

  cmpclr_compare #(.CW(CW)) u_cmp (
    .count   (count),
    .top_val (top_val),
    .mode    (cmp_mode),
    .hit     (hit)
  );

  always_comb begin
    unique case (tm)
      TRG_SLOW:  trig = slow_fire;
      TRG_EVENT: trig = ev_rise;
      default:   trig = 1'b0;
    endcase
    match = trig && hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clear_pulse <= 1'b0;
      match_flag  <= 1'b0;
    end else begin
      clear_pulse <= match;
      if (match)         match_flag <= 1'b1;
      else if (flag_clr) match_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/cmpclr_unit_chk.sv
module cmpclr_unit_chk #(
  parameter int SEL_W = 3,
  parameter int NCH   = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       trig_mode,
  input logic [1:0]       cmp_mode,
  input logic [SEL_W-1:0] ev_sel,
  input logic             gate_en,
  input logic             flag_clr,
  input logic             clear_pulse,
  input logic             match_flag,
  input logic             count_gate
);
  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!clear_pulse && !match_flag && count_gate));

  // R2
  a_r2_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (trig_mode == 2'd0 || trig_mode == 2'd3) |=> !clear_pulse);

  // R7
  a_r7_no_channel: assert property (@(posedge clk) disable iff (rst)
    (trig_mode == 2'd2 && 32'(ev_sel) >= NCH) |=> !clear_pulse);

  // R10
  a_r10_rsvd_cmp: assert property (@(posedge clk) disable iff (rst)
    (cmp_mode == 2'd3) |=> !clear_pulse);

  // R11
  a_r11_pulse_sets_flag: assert property (@(posedge clk) disable iff (rst)
    clear_pulse |-> match_flag);

  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (match_flag && !flag_clr) |=> match_flag);

  a_r11_flag_clear: assert property (@(posedge clk) disable iff (rst)
    flag_clr |=> (!match_flag || clear_pulse));

  // R12
  a_r12_gate_open: assert property (@(posedge clk) disable iff (rst)
    !gate_en |=> count_gate);

  a_r12_gate_no_channel: assert property (@(posedge clk) disable iff (rst)
    (gate_en && 32'(ev_sel) >= NCH) |=> !count_gate);
endmodule

bind cmpclr_unit cmpclr_unit_chk #(.SEL_W(SEL_W), .NCH(NCH)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .trig_mode   (trig_mode),
  .cmp_mode    (cmp_mode),
  .ev_sel      (ev_sel),
  .gate_en     (gate_en),
  .flag_clr    (flag_clr),
  .clear_pulse (clear_pulse),
  .match_flag  (match_flag),
  .count_gate  (count_gate)
);

// File: tb/cmpclr_unit_tb_top.sv
`timescale 1ns/1ps
module cmpclr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        slow_tick;
  logic [15:0] count, top_val;
  logic [1:0]  trig_mode, presc, cmp_mode;
  logic [5:0]  ev_in;
  logic [2:0]  ev_sel;
  logic        ev_invert, gate_en, flag_clr;
  logic        clear_pulse, match_flag, count_gate;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  cmpclr_unit dut_i (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .count(count),
    .top_val(top_val), .trig_mode(trig_mode), .presc(presc),
    .cmp_mode(cmp_mode), .ev_in(ev_in), .ev_sel(ev_sel),
    .ev_invert(ev_invert), .gate_en(gate_en), .flag_clr(flag_clr),
    .clear_pulse(clear_pulse), .match_flag(match_flag),
    .count_gate(count_gate)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<=100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  function automatic logic exp_hit(input logic [15:0] c, input logic [15:0] t,
                                   input logic [1:0] m);
    case (m)
      2'd0: return c <= t;
      2'd1: return c >= t;
      2'd2: return (c <= {8'd0, t[15:8]}) && (c >= {8'd0, t[7:0]});
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // one tick, returns pulse seen on the sampling edge, then one idle cycle
  task automatic do_tick(output logic p, output logic after);
    slow_tick = 1'b1;
    step();
    slow_tick = 1'b0;
    p = clear_pulse;
    step();
    after = clear_pulse;
  endtask

  initial begin
    logic p, a;
    int bad;
    int seed;
    seed = 7;
    void'($urandom(seed));
    rst = 1'b1; slow_tick = 1'b0; count = '0; top_val = '0;
    trig_mode = 2'd0; presc = 2'd0; cmp_mode = 2'd0; ev_in = '0;
    ev_sel = 3'd0; ev_invert = 1'b0; gate_en = 1'b0; flag_clr = 1'b0;
    step(); step();
    rst = 1'b0;
    chk("R1 clear_pulse", clear_pulse, 0);
    chk("R1 match_flag", match_flag, 0);
    chk("R1 count_gate", count_gate, 1);

    // always-matching compare for trigger tests
    count = 16'd0; top_val = 16'hFFFF; cmp_mode = 2'd0;

    // R2: modes 0 and 3 quiet
    bad = 0;
    for (int md = 0; md < 4; md += 3) begin
      trig_mode = 2'(md); ev_sel = 3'd0; step();
      for (int i = 0; i < 4; i++) begin
        do_tick(p, a); bad += p;
        ev_in[0] = ~ev_in[0]; step(); bad += clear_pulse;
      end
    end
    ev_in = '0;
    chk("R2 pulses in off modes", bad, 0);

    // R3: prescaler periods
    trig_mode = 2'd1;
    for (int pc = 0; pc < 4; pc++) begin
      int div;
      div = 1 << pc;
      presc = 2'(pc); step();
      bad = 0;
      for (int i = 1; i <= 16; i++) begin
        do_tick(p, a);
        if (p != ((i % div) == 0)) bad++;
        if (a != 1'b0) bad++;
      end
      chk($sformatf("R3 divide-by-%0d mismatches", div), bad, 0);
    end

    // R4: restart on prescaler code change, tick in change cycle ignored
    presc = 2'd2; step();
    do_tick(p, a); do_tick(p, a);
    presc = 2'd1; slow_tick = 1'b1; step(); slow_tick = 1'b0;
    chk("R4 tick in change cycle", clear_pulse, 0);
    do_tick(p, a); chk("R4 first tick after restart", p, 0);
    do_tick(p, a); chk("R4 second tick after restart", p, 1);
    // mode change also restarts
    do_tick(p, a);
    trig_mode = 2'd0; step(); trig_mode = 2'd1; step();
    do_tick(p, a); chk("R4 after mode change tick1", p, 0);
    do_tick(p, a); chk("R4 after mode change tick2", p, 1);

    // R5: events ignored in mode 1
    ev_sel = 3'd3; ev_in[3] = 1'b1; step();
    chk("R5 edge ignored in slow mode", clear_pulse, 0);
    ev_in[3] = 1'b0;
    trig_mode = 2'd2; step(); step();
    ev_in[3] = 1'b1; step();
    chk("R5 rising edge selected channel", clear_pulse, 1);
    step();
    chk("R5 level held no retrigger", clear_pulse, 0);
    ev_in[1] = 1'b1; step();
    chk("R5 unselected channel ignored", clear_pulse, 0);
    do_tick(p, a);
    chk("R5 tick ignored in event mode", p, 0);
    ev_in = '0; step();

    // R6: polarity
    ev_invert = 1'b1; step(); step();
    ev_in[3] = 1'b1; step();
    chk("R6 raw rise with invert", clear_pulse, 0);
    ev_in[3] = 1'b0; step();
    chk("R6 raw fall with invert", clear_pulse, 1);
    ev_invert = 1'b0; step(); step();

    // R7: codes 6 and 7
    bad = 0;
    for (int s = 6; s < 8; s++) begin
      ev_sel = 3'(s); step();
      for (int i = 0; i < 3; i++) begin
        ev_in = 6'h3F; step(); bad += clear_pulse;
        ev_in = 6'h00; step(); bad += clear_pulse;
      end
    end
    chk("R7 pulses on no-channel codes", bad, 0);

    // R11: flag clear, set-wins
    flag_clr = 1'b1; step(); flag_clr = 1'b0;
    chk("R11 flag cleared", match_flag, 0);
    ev_sel = 3'd2; step();
    ev_in[2] = 1'b1; flag_clr = 1'b1; step(); flag_clr = 1'b0;
    chk("R11 set wins over clear", match_flag, 1);
    step(); chk("R11 flag sticky", match_flag, 1);
    chk("R11 single-cycle pulse", clear_pulse, 0);
    flag_clr = 1'b1; step(); flag_clr = 1'b0;
    cmp_mode = 2'd1; count = 16'd5; top_val = 16'd9;
    ev_in[2] = 1'b0; step(); ev_in[2] = 1'b1; step();
    chk("R11 no match leaves flag clear", match_flag, 0);
    ev_in = '0;

    // R12: count gate
    gate_en = 1'b1; ev_sel = 3'd4; ev_in[4] = 1'b1; step();
    chk("R12 gate follows high level", count_gate, 1);
    ev_in[4] = 1'b0; step();
    chk("R12 gate follows low level", count_gate, 0);
    ev_invert = 1'b1; step();
    chk("R12 gate with invert", count_gate, 1);
    ev_sel = 3'd7; step();
    chk("R12 gate no channel", count_gate, 0);
    gate_en = 1'b0; step();
    chk("R12 gate disabled open", count_gate, 1);
    ev_invert = 1'b0; ev_sel = 3'd0;

    // R8-R10 directed bounds, slow mode divide-by-1
    trig_mode = 2'd1; presc = 2'd0; step();
    cmp_mode = 2'd0; top_val = 16'd100;
    count = 16'd100; do_tick(p, a); chk("R8 equal", p, 1);
    count = 16'd101; do_tick(p, a); chk("R8 above", p, 0);
    cmp_mode = 2'd1;
    count = 16'd100; do_tick(p, a); chk("R9 equal", p, 1);
    count = 16'd99;  do_tick(p, a); chk("R9 below", p, 0);
    cmp_mode = 2'd2; top_val = {8'd40, 8'd10};
    count = 16'd10; do_tick(p, a); chk("R10 low bound", p, 1);
    count = 16'd40; do_tick(p, a); chk("R10 high bound", p, 1);
    count = 16'd9;  do_tick(p, a); chk("R10 below window", p, 0);
    count = 16'd41; do_tick(p, a); chk("R10 above window", p, 0);
    cmp_mode = 2'd3; count = 16'd0; top_val = 16'hFFFF;
    do_tick(p, a); chk("R10 reserved code", p, 0);

    // random compare patterns (R8 R9 R10)
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      cmp_mode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 0) begin
        count   = 16'($urandom_range(0, 60));
        top_val = {8'($urandom_range(0, 60)), 8'($urandom_range(0, 60))};
      end else begin
        count   = 16'($urandom);
        top_val = 16'($urandom);
      end
      do_tick(p, a);
      if (p != exp_hit(count, top_val, cmp_mode)) begin
        bad++;
        $display("FAIL R8/R9/R10 random: count=%0d top=%h mode=%0d actual=%0d expected=%0d",
                 count, top_val, cmp_mode, p, exp_hit(count, top_val, cmp_mode));
      end
    end
    checks = checks + 1;
    if (bad != 0) failures = failures + 1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule